// File: doc/BRIEF.md
# SD Single-Block Read Data Receiver

This block takes in one block of read data from a one-bit SD data line. The command side of the host issues a single-block read and pulses a trigger in the clock cycle in which the read command's end bit leaves the host. From that point the receiver waits for the card's access delay. During that delay the line idles high. The receiver then detects a zero start bit. It puts the payload together into bytes, most significant bit first, and presents each byte on a byte-wide stream with a one-cycle valid strobe.

The payload length in bytes comes from the block length input, which is captured when the trigger arrives. A 16-bit checksum follows the payload. The receiver compares it with a value it computes over the payload itself, and then samples a closing end bit. One cycle after the end bit, a done pulse is given together with the checksum-mismatch and framing-error flags. If the access delay runs past a parameterised limit and no start bit has arrived, the receiver pulses a timeout and returns to idle.

Top module: `sd_blk_rx`

## Requirements
- R1: After reset, byte_vld_o, blk_done_o, crc_err_o, frame_err_o and timeout_o are all low and the receiver is idle.
- R2: While idle, a high cmd_end_i starts the access wait. In the wait, high samples of dat_i are ignored. The first low sample within NAC_MAX samples after the trigger cycle is the start bit, and the payload bits follow it directly.
- R3: If all NAC_MAX samples of dat_i after the trigger cycle are high, timeout_o goes high for exactly one cycle, in the cycle after the last of those samples. The receiver returns to idle and emits no byte and no done pulse.
- R4: The payload is blk_len bytes, with each byte's bits sent MSB first. byte_vld_o is high for exactly one cycle per byte, in the cycle after that byte's eighth bit, with byte_o holding the byte.
- R5: The 16 bits after the payload are the expected checksum, sent MSB first. The receiver computes the checksum over the payload bits only, with polynomial x^16+x^12+x^5+1 (0x1021) and a starting value of zero.
- R6: blk_done_o is a one-cycle pulse in the cycle after the end bit, which is the sample that follows the 16 checksum bits. In that cycle crc_err_o is high exactly when the received checksum differs from the computed one.
- R7: In the done cycle, frame_err_o is high exactly when the end bit was sampled low. crc_err_o and frame_err_o are never high outside a done cycle.
- R8: A high cmd_end_i while a block is being received has no effect. The current block completes with its own length and flags.
- R9: blk_len_i is sampled only in the trigger cycle. Changes to it after that do not change the number of bytes received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; dat_i is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_end_i | input | 1 | High in the cycle of the read command's end bit |
| blk_len_i | input | LEN_W | Block length in bytes, at least 1 |
| dat_i | input | 1 | Serial data line |
| byte_o | output | 8 | Assembled payload byte |
| byte_vld_o | output | 1 | byte_o valid strobe |
| blk_done_o | output | 1 | Block complete pulse |
| crc_err_o | output | 1 | Checksum mismatch, valid with blk_done_o |
| frame_err_o | output | 1 | End bit sampled low, valid with blk_done_o |
| timeout_o | output | 1 | Access delay exceeded NAC_MAX samples |

## Verification
The assertions take three things for granted about the inputs:
- blk_len_i is at least one when a trigger is accepted.
- dat_i is already synchronous to clk_i.
- NAC_MAX is at least two.

The bench keeps within these limits. It drives every input on the falling edge, and it draws random lengths from one upward and random access gaps from zero to NAC_MAX-1. Timeout runs hold the line high for the full window. Triggers during a block and length changes after a trigger are applied only in directed runs, so that the ignored-input requirements can be checked at the outputs.

// File: rtl/sd_blk_rx_pkg.sv
package sd_blk_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rx_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam int unsigned CRC_W    = 16;
endpackage

// File: rtl/sd_rx_nac_timer.sv
module sd_rx_nac_timer #(
  parameter int unsigned NAC_MAX = 256,
  localparam int unsigned CW     = (NAC_MAX > 2) ? $clog2(NAC_MAX) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == CW'(NAC_MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (inc_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NAC_MAX - 1));
  p_clr_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sd_rx_crc16.sv
module sd_rx_crc16
  import sd_blk_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  assign fb = crc_o[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= '0;
    else if (clr_i)   crc_o <= '0;
    else if (en_i)    crc_o <= {crc_o[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  p_crc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_o));
  p_crc_init_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == '0);
endmodule

// File: rtl/sd_rx_deser.sv
module sd_rx_deser #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             last_o
);
  logic [6:0]       sh_q;
  logic [2:0]       bit_cnt_q;
  logic [LEN_W-1:0] byte_cnt_q;
  logic             byte_end;

  assign byte_end = en_i && (bit_cnt_q == 3'd7);
  assign last_o   = byte_end && (byte_cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (clr_i) begin
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
      end else if (en_i) begin
        sh_q      <= {sh_q[5:0], bit_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (byte_end) begin
          byte_o     <= {sh_q, bit_i};
          byte_vld_o <= 1'b1;
          byte_cnt_q <= byte_cnt_q + 1'b1;
        end
      end
    end
  end

  p_byte_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> byte_cnt_q < len_i);
  p_vld_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/sd_blk_rx.sv
module sd_blk_rx
  import sd_blk_rx_pkg::*;
#(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned NAC_MAX = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_end_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic             dat_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             blk_done_o,
  output logic             crc_err_o,
  output logic             frame_err_o,
  output logic             timeout_o
);
  localparam int unsigned CCW = $clog2(CRC_W);

  rx_state_e        state_q;
  logic [LEN_W-1:0] len_q;
  logic [CRC_W-1:0] rx_crc_q;
  logic [CRC_W-1:0] crc_calc;
  logic [CCW-1:0]   crc_cnt_q;
  logic             nac_expired;
  logic             data_last;
  logic             in_wait;
  logic             in_data;

  assign in_wait = (state_q == ST_WAIT);
  assign in_data = (state_q == ST_DATA);

  sd_rx_nac_timer #(.NAC_MAX(NAC_MAX)) i_nac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!in_wait),
    .inc_i     (in_wait && dat_i),
    .expired_o (nac_expired)
  );

  sd_rx_crc16 i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (in_wait),
    .en_i   (in_data),
    .bit_i  (dat_i),
    .crc_o  (crc_calc)
  );

  sd_rx_deser #(.LEN_W(LEN_W)) i_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (in_wait),
    .en_i       (in_data),
    .bit_i      (dat_i),
    .len_i      (len_q),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .last_o     (data_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      rx_crc_q    <= '0;
      crc_cnt_q   <= '0;
      blk_done_o  <= 1'b0;
      crc_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      blk_done_o  <= 1'b0;
      crc_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      timeout_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_end_i) begin
          len_q   <= blk_len_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!dat_i) begin
            state_q <= ST_DATA;
          end else if (nac_expired) begin
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_DATA: if (data_last) begin
          crc_cnt_q <= '0;
          state_q   <= ST_CRC;
        end
        ST_CRC: begin
          rx_crc_q  <= {rx_crc_q[CRC_W-2:0], dat_i};
          crc_cnt_q <= crc_cnt_q + 1'b1;
          if (crc_cnt_q == CCW'(CRC_W - 1)) state_q <= ST_END;
        end
        ST_END: begin
          blk_done_o  <= 1'b1;
          crc_err_o   <= (rx_crc_q != crc_calc);
          frame_err_o <= !dat_i;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_vld_from_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> ($past(state_q) == ST_DATA));
  p_crc_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CRC && $past(state_q) == ST_CRC) |-> $stable(crc_calc));
  p_done_after_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |-> ($past(state_q) == ST_END));
  p_flags_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_err_o || frame_err_o) |-> blk_done_o);
  p_done_timeout_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({blk_done_o, timeout_o}));
  p_timeout_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (state_q == ST_IDLE && $past(state_q) == ST_WAIT));
  p_busy_trig_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_end_i && state_q != ST_IDLE && state_q != ST_WAIT) |=> state_q != ST_WAIT);
  p_len_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(len_q));
endmodule

// File: tb/test_sd_blk_rx.sv
module test_sd_blk_rx;
  localparam int unsigned LEN_W = 12;
  localparam int unsigned NAC   = 40;
  localparam time         TCLK  = 20ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_end_i = 1'b0;
  logic [LEN_W-1:0] blk_len_i = '0;
  logic             dat_i = 1'b1;
  logic [7:0]       byte_o;
  logic             byte_vld_o, blk_done_o, crc_err_o, frame_err_o, timeout_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] tx_buf [0:1023];
  logic [7:0] rx_buf [0:1023];
  int rx_n = 0;

  always #(TCLK/2) clk_i = ~clk_i;

  sd_blk_rx #(.LEN_W(LEN_W), .NAC_MAX(NAC)) i_sd_blk_rx (.*);

  always @(negedge clk_i) begin
    if (byte_vld_o) begin
      if (rx_n < 1024) rx_buf[rx_n] = byte_o;
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = '0;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ tx_buf[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c ^= 16'h1021;
      end
    return c;
  endfunction

  task automatic run_block(input int len, input int gap, input bit bad_crc,
                           input bit bad_end, input bit mid_trig, input bit len_chg);
    logic [15:0] crc;
    bit ok;
    crc = crc_of(len) ^ (bad_crc ? 16'h0001 : 16'h0000);
    rx_n = 0;
    @(negedge clk_i);
    cmd_end_i = 1'b1; blk_len_i = LEN_W'(len); dat_i = 1'b1;
    @(negedge clk_i);
    cmd_end_i = 1'b0;
    if (len_chg) blk_len_i = LEN_W'(len + 3);
    for (int i = 0; i < gap; i++) begin dat_i = 1'b1; @(negedge clk_i); end
    dat_i = 1'b0; @(negedge clk_i);
    for (int i = 0; i < len; i++)
      for (int b = 7; b >= 0; b--) begin
        dat_i = tx_buf[i][b];
        cmd_end_i = mid_trig && (i == len / 2) && (b == 3);
        @(negedge clk_i);
      end
    cmd_end_i = 1'b0;
    for (int b = 15; b >= 0; b--) begin
      dat_i = crc[b];
      chk(blk_done_o == 1'b0, "R6 no early done", blk_done_o, 0);
      @(negedge clk_i);
    end
    dat_i = !bad_end;
    @(negedge clk_i);
    dat_i = 1'b1;
    chk(blk_done_o == 1'b1, "R6 done after end bit", blk_done_o, 1);
    chk(crc_err_o == bad_crc, "R6 crc flag", crc_err_o, bad_crc);
    chk(frame_err_o == bad_end, "R7 frame flag", frame_err_o, bad_end);
    chk(rx_n == len, mid_trig ? "R8 byte count" : (len_chg ? "R9 byte count" : "R4 byte count"),
        rx_n, len);
    ok = 1;
    for (int i = 0; i < len && i < rx_n; i++) if (rx_buf[i] !== tx_buf[i]) ok = 0;
    chk(ok, "R2 R4 R5 payload bytes", rx_n, len);
    @(negedge clk_i);
    chk(blk_done_o == 1'b0 && crc_err_o == 1'b0 && frame_err_o == 1'b0,
        "R7 flags one cycle", {blk_done_o, crc_err_o, frame_err_o}, 0);
  endtask

  task automatic run_timeout();
    rx_n = 0;
    @(negedge clk_i);
    cmd_end_i = 1'b1; blk_len_i = LEN_W'(4); dat_i = 1'b1;
    for (int j = 1; j <= NAC; j++) begin
      @(negedge clk_i);
      cmd_end_i = 1'b0;
      chk(timeout_o == 1'b0, "R3 no early timeout", timeout_o, 0);
    end
    @(negedge clk_i);
    chk(timeout_o == 1'b1, "R3 timeout pulse", timeout_o, 1);
    @(negedge clk_i);
    chk(timeout_o == 1'b0 && blk_done_o == 1'b0, "R3 single pulse", timeout_o, 0);
    chk(rx_n == 0, "R3 no bytes", rx_n, 0);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk({byte_vld_o, blk_done_o, crc_err_o, frame_err_o, timeout_o} == 5'b0,
        "R1 reset outputs", {byte_vld_o, blk_done_o, crc_err_o, frame_err_o, timeout_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(timeout_o == 1'b0 && byte_vld_o == 1'b0, "R1 idle after reset", timeout_o, 0);

    // directed corners
    for (int i = 0; i < 4; i++) tx_buf[i] = 8'hA5 ^ 8'(i * 17);
    run_block(1, 0, 0, 0, 0, 0);
    run_block(4, NAC - 1, 0, 0, 0, 0);
    run_block(4, 3, 1, 0, 0, 0);
    run_block(4, 3, 0, 1, 0, 0);
    run_timeout();
    for (int i = 0; i < 8; i++) tx_buf[i] = 8'($urandom);
    run_block(8, 5, 0, 0, 1, 0);
    run_block(8, 2, 0, 0, 0, 1);
    for (int i = 0; i < 512; i++) tx_buf[i] = 8'($urandom);
    run_block(512, 7, 0, 0, 0, 0);

    // constrained random
    for (int n = 0; n < 30; n++) begin
      int len = 1 + int'($urandom_range(31));
      int gap = int'($urandom_range(NAC - 1));
      bit bc = ($urandom_range(3) == 0);
      bit be = ($urandom_range(5) == 0);
      for (int i = 0; i < len; i++) tx_buf[i] = 8'($urandom);
      run_block(len, gap, bc, be, 0, 0);
    end
    run_timeout();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule